// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block decides whether the local device is being addressed on an I2C bus. A bit-level shifter upstream signals each START or repeated START. It also presents every completed byte with a one-cycle valid strobe. The matcher inspects only the first byte that follows a START. It compares the upper seven bits of that byte with a programmable own address. When general-call recognition is enabled, it also compares them with the all-zero general-call address.

On a hit, the block pulses a match event for the control logic. A separate flag tells a general-call hit apart from an own-address hit. The block captures the direction bit and chooses the acknowledge level to drive in the ninth clock. The matcher runs on the bus-side clock, so it keeps working while the system side sleeps. A match seen during sleep raises a wake request that stays up until the system reports that it is awake.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), match_o, gcall_o, dir_rd_o and wake_o are 0 and ack_drive_o is 1 (NACK).
- R2: If the first byte after a START has bits [7:1] equal to a non-zero own_addr_i, match_o is 1 for exactly the one cycle after the byte_valid_i edge. An own address of zero never produces an own-address hit.
- R3: With gc_en_i = 1, the first byte 8'h00 (address zero, write) is a match. The byte 8'h01 (address zero, read) is never a match. With gc_en_i = 0, neither byte is a match.
- R4: gcall_o is updated at every evaluation. It is 1 after a general-call hit and 0 after an own-address hit or a miss.
- R5: dir_rd_o takes bit [0] of the byte (1 = read, 0 = write) only when that byte matches. After a miss it keeps its previous value.
- R6: ack_drive_o is updated at every evaluation. It is 0 (ACK) when the byte matches and ack_en_i = 1, and 1 (NACK) otherwise, including a match while ack_en_i = 0.
- R7: Bytes after the first byte of a transfer produce no match. They leave gcall_o, dir_rd_o and ack_drive_o unchanged.
- R8: A repeated START re-arms the matcher, so the next byte is evaluated again.
- R9: A match while sleep_i = 1 sets wake_o in the same cycle as match_o. wake_o stays 1 while sleep_i stays 1, and clears the cycle after sleep_i is seen low. A match while sleep_i = 0 does not set wake_o.
- R10: If start_i and byte_valid_i are high in the same cycle, the byte is not evaluated. The matcher is armed for the next byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus-side clock, running during sleep |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse on START or repeated START |
| byte_valid_i | input | 1 | One-cycle strobe: rx_byte_i holds a completed byte |
| rx_byte_i | input | 8 | Received byte, address in [7:1], direction in [0] |
| own_addr_i | input | 7 | Programmable own address |
| gc_en_i | input | 1 | Enables general-call recognition |
| ack_en_i | input | 1 | Allows acknowledging a matched address |
| sleep_i | input | 1 | System clock domain is asleep |
| match_o | output | 1 | One-cycle match event |
| gcall_o | output | 1 | Last evaluation was a general-call hit |
| dir_rd_o | output | 1 | Direction of the last matched byte, 1 = read |
| wake_o | output | 1 | Wake request to the system domain |
| ack_drive_o | output | 1 | Level for the acknowledge bit, 0 = ACK, 1 = NACK |

## Verification
The bench builds the block with its default parameters: a 7-bit address and general-call support present. This small address space allows a full sweep of all 256 first-byte values. The sweep runs against several own addresses, including zero and all-ones. It covers all four settings of the general-call and acknowledge enables. Each hit, miss, general-call split, direction capture and ACK level is predicted arithmetically from the byte. Directed sequences then cover trailing bytes, repeated STARTs, a START that collides with a byte strobe, and wake behaviour across sleep transitions.

// File: rtl/i2cam_pkg.sv
// Package: shared types for the address matcher.
// Assumes: 7-bit addressing; the byte carries the address in its upper bits
// and the direction in bit 0.
package i2cam_pkg;

    // Outcome of one address comparison
    typedef struct packed {
        logic own_hit;   // upper bits equal the own address
        logic gc_hit;    // valid general call (address zero, write)
    } cmp_result_t;

    // Acknowledge levels as driven on SDA
    localparam logic ACK_LVL  = 1'b0;
    localparam logic NACK_LVL = 1'b1;

endpackage

// File: rtl/i2cam_arm.sv
// Module: i2cam_arm
// Tracks whether the next received byte is the first after a START.
// Assumes: start_i and byte_valid_i are single-cycle pulses from the shifter.
// A START in the same cycle as a byte strobe wins: the byte is dropped and
// the tracker is armed for the following byte.
module i2cam_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic byte_valid_i,
    output logic eval_o
);

    logic armed_q;

    // Arm on START, disarm once the first byte has been consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (start_i) begin
            armed_q <= 1'b1;
        end else if (byte_valid_i) begin
            armed_q <= 1'b0;
        end
    end

    // Evaluate only an armed byte that does not collide with a START
    always_comb begin
        eval_o = armed_q && byte_valid_i && !start_i;
    end

endmodule

// File: rtl/i2cam_cmp.sv
// Module: i2cam_cmp
// Combinational address comparison against the own address and, when
// enabled, the general-call address.
// Assumes: an own address of zero is reserved and never matches; the general
// call is only valid with the write direction.
module i2cam_cmp
    import i2cam_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter bit GC_SUPPORT = 1'b1
) (
    input  logic [ADDR_W:0]   rx_byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    output cmp_result_t       res_o
);

    localparam int BYTE_W = ADDR_W + 1;

    logic [ADDR_W-1:0] rx_addr;
    logic              rx_rd;

    // Split the byte into address and direction fields
    always_comb begin
        rx_addr = rx_byte_i[BYTE_W-1:1];
        rx_rd   = rx_byte_i[0];
    end

    // Own-address comparison, reserved zero excluded
    always_comb begin
        res_o.own_hit = (own_addr_i != '0) && (rx_addr == own_addr_i);
    end

    generate
        if (GC_SUPPORT) begin : g_gc
            // General call: all-zero address with write direction, if enabled
            always_comb begin
                res_o.gc_hit = gc_en_i && (rx_addr == '0) && !rx_rd;
            end
        end else begin : g_no_gc
            // Recognition not built: never a general-call hit
            always_comb begin
                res_o.gc_hit = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/i2cam_resp.sv
// Module: i2cam_resp
// Registers the response to an evaluated address byte: match pulse,
// general-call flag, direction and acknowledge level.
// Assumes: eval_i is high for exactly one cycle per evaluated byte.
module i2cam_resp
    import i2cam_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        eval_i,
    input  cmp_result_t res_i,
    input  logic        rx_rd_i,
    input  logic        ack_en_i,
    output logic        match_o,
    output logic        gcall_o,
    output logic        dir_rd_o,
    output logic        ack_drive_o
);

    logic hit;

    // Any recognised address
    always_comb begin
        hit = res_i.own_hit || res_i.gc_hit;
    end

    // Match event: a single-cycle pulse after an evaluated hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o <= 1'b0;
        end else begin
            match_o <= eval_i && hit;
        end
    end

    // General-call flag and ACK level refresh at every evaluation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcall_o     <= 1'b0;
            ack_drive_o <= NACK_LVL;
        end else if (eval_i) begin
            gcall_o     <= res_i.gc_hit && !res_i.own_hit;
            ack_drive_o <= (hit && ack_en_i) ? ACK_LVL : NACK_LVL;
        end
    end

    // Direction captured only on a hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_rd_o <= 1'b0;
        end else if (eval_i && hit) begin
            dir_rd_o <= rx_rd_i;
        end
    end

endmodule

// File: rtl/i2cam_wake.sv
// Module: i2cam_wake
// Raises and holds a wake request when an address hit arrives while the
// system side sleeps.
// Assumes: sleep_i is synchronous to clk.
module i2cam_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_evt_i,
    input  logic sleep_i,
    output logic wake_o
);

    // Set on a hit during sleep, clear once the system is awake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_o <= 1'b0;
        end else if (!sleep_i) begin
            wake_o <= 1'b0;
        end else if (hit_evt_i) begin
            wake_o <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_addr_matcher.sv
// Module: i2c_addr_matcher
// Top of the address matcher: arms on START, compares the first byte,
// registers the response and drives the wake request.
// Assumes: all inputs are synchronous to clk, which keeps running while the
// system domain sleeps.
module i2c_addr_matcher
    import i2cam_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter bit GC_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_valid_i,
    input  logic [ADDR_W:0]   rx_byte_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              gc_en_i,
    input  logic              ack_en_i,
    input  logic              sleep_i,
    output logic              match_o,
    output logic              gcall_o,
    output logic              dir_rd_o,
    output logic              wake_o,
    output logic              ack_drive_o
);

    logic        eval;
    logic        hit_evt;
    cmp_result_t res;

    i2cam_arm u_arm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .eval_o       (eval)
    );

    i2cam_cmp #(
        .ADDR_W     (ADDR_W),
        .GC_SUPPORT (GC_SUPPORT)
    ) u_cmp (
        .rx_byte_i  (rx_byte_i),
        .own_addr_i (own_addr_i),
        .gc_en_i    (gc_en_i),
        .res_o      (res)
    );

    i2cam_resp u_resp (
        .clk         (clk),
        .rst_n       (rst_n),
        .eval_i      (eval),
        .res_i       (res),
        .rx_rd_i     (rx_byte_i[0]),
        .ack_en_i    (ack_en_i),
        .match_o     (match_o),
        .gcall_o     (gcall_o),
        .dir_rd_o    (dir_rd_o),
        .ack_drive_o (ack_drive_o)
    );

    // Hit event seen by the wake logic
    always_comb begin
        hit_evt = eval && (res.own_hit || res.gc_hit);
    end

    i2cam_wake u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_evt_i (hit_evt),
        .sleep_i   (sleep_i),
        .wake_o    (wake_o)
    );

endmodule

// File: rtl/i2c_addr_matcher_chk.sv
// Module: i2c_addr_matcher_chk
// Port-level properties of the address matcher, bound to the top.
module i2c_addr_matcher_chk #(
    parameter int ADDR_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic            byte_valid_i,
    input logic [ADDR_W:0] rx_byte_i,
    input logic            ack_en_i,
    input logic            sleep_i,
    input logic            match_o,
    input logic            gcall_o,
    input logic            dir_rd_o,
    input logic            wake_o,
    input logic            ack_drive_o
);

    // R2
    match_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);

    // R7
    match_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(byte_valid_i) && !$past(start_i)));

    // R3
    gcall_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && gcall_o) |-> ($past(rx_byte_i) == '0));

    // R5
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> $stable(dir_rd_o));

    // R6
    ack_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_drive_o == 1'b0 && $changed(ack_drive_o)) |-> ($past(ack_en_i) && match_o));

    // R9
    wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sleep_i) |-> !wake_o);

    // R9
    wake_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> match_o);

endmodule

bind i2c_addr_matcher i2c_addr_matcher_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .byte_valid_i (byte_valid_i),
    .rx_byte_i    (rx_byte_i),
    .ack_en_i     (ack_en_i),
    .sleep_i      (sleep_i),
    .match_o      (match_o),
    .gcall_o      (gcall_o),
    .dir_rd_o     (dir_rd_o),
    .wake_o       (wake_o),
    .ack_drive_o  (ack_drive_o)
);

// File: tb/i2c_addr_matcher_tb.sv
// Bench: sweeps all first-byte values against several own addresses and
// enable settings, then directed sequences for trailing bytes, repeated
// START, START/strobe collision and wake behaviour.
module i2c_addr_matcher_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       start_i;
    logic       byte_valid_i;
    logic [7:0] rx_byte_i;
    logic [6:0] own_addr_i;
    logic       gc_en_i;
    logic       ack_en_i;
    logic       sleep_i;
    logic       match_o, gcall_o, dir_rd_o, wake_o, ack_drive_o;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic exp_dir;
    logic exp_gc;
    logic exp_ack;

    always #10 clk = ~clk;

    i2c_addr_matcher u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .byte_valid_i (byte_valid_i),
        .rx_byte_i    (rx_byte_i),
        .own_addr_i   (own_addr_i),
        .gc_en_i      (gc_en_i),
        .ack_en_i     (ack_en_i),
        .sleep_i      (sleep_i),
        .match_o      (match_o),
        .gcall_o      (gcall_o),
        .dir_rd_o     (dir_rd_o),
        .wake_o       (wake_o),
        .ack_drive_o  (ack_drive_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Pulse START for one cycle
    task automatic send_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Present one byte; returns at the negedge after the capturing edge
    task automatic send_byte(input logic [7:0] b);
        byte_valid_i = 1'b1;
        rx_byte_i    = b;
        @(negedge clk);
        byte_valid_i = 1'b0;
    endtask

    // Predicted evaluation of a first byte
    task automatic predict(input logic [7:0] b, output logic m);
        logic own, gc;
        own = (own_addr_i != 7'd0) && (b[7:1] == own_addr_i);
        gc  = gc_en_i && (b == 8'h00);
        m   = own || gc;
        exp_gc  = gc && !own;
        exp_ack = !(m && ack_en_i);
        if (m) exp_dir = b[0];
    endtask

    initial begin
        logic m;
        rst_n = 1'b0; start_i = 1'b0; byte_valid_i = 1'b0; rx_byte_i = '0;
        own_addr_i = 7'h2A; gc_en_i = 1'b0; ack_en_i = 1'b1; sleep_i = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 match", match_o, 1'b0);
        chk("R1 gcall", gcall_o, 1'b0);
        chk("R1 dir", dir_rd_o, 1'b0);
        chk("R1 wake", wake_o, 1'b0);
        chk("R1 ack", ack_drive_o, 1'b1);
        rst_n = 1'b1;
        exp_dir = 1'b0;

        // R2 R3 R4 R5 R6: full sweep
        for (int oi = 0; oi < 4; oi++) begin
            case (oi)
                0: own_addr_i = 7'h2A;
                1: own_addr_i = 7'h7F;
                2: own_addr_i = 7'h00;
                default: own_addr_i = 7'h01;
            endcase
            for (int cfg = 0; cfg < 4; cfg++) begin
                gc_en_i  = cfg[0];
                ack_en_i = cfg[1];
                for (int b = 0; b < 256; b++) begin
                    send_start();
                    send_byte(b[7:0]);
                    predict(b[7:0], m);
                    chk("R2/R3 match", match_o, m);
                    chk("R4 gcall", gcall_o, exp_gc);
                    chk("R5 dir", dir_rd_o, exp_dir);
                    chk("R6 ack", ack_drive_o, exp_ack);
                    @(negedge clk);
                    chk("R2 pulse width", match_o, 1'b0);
                end
            end
        end

        // R7: trailing bytes do not match and leave outputs alone
        own_addr_i = 7'h2A; gc_en_i = 1'b1; ack_en_i = 1'b1;
        send_start();
        send_byte(8'h55);                 // own address, read
        chk("R7 first hit", match_o, 1'b1);
        send_byte(8'h54);                 // own address, write, trailing
        chk("R7 no trailing match", match_o, 1'b0);
        chk("R7 dir held", dir_rd_o, 1'b1);
        chk("R7 ack held", ack_drive_o, 1'b0);
        send_byte(8'h00);                 // general call, trailing
        chk("R7 no trailing gc", match_o, 1'b0);
        chk("R7 gcall held", gcall_o, 1'b0);

        // R8: repeated START re-arms
        send_start();
        send_byte(8'h00);
        chk("R8 rearm match", match_o, 1'b1);
        chk("R8 rearm gcall", gcall_o, 1'b1);
        chk("R8 rearm dir", dir_rd_o, 1'b0);

        // R10: START colliding with strobe drops the byte, arms for the next
        @(negedge clk);
        start_i = 1'b1; byte_valid_i = 1'b1; rx_byte_i = 8'h54;
        @(negedge clk);
        start_i = 1'b0; byte_valid_i = 1'b0;
        chk("R10 collision ignored", match_o, 1'b0);
        send_byte(8'h55);
        chk("R10 next byte evaluated", match_o, 1'b1);
        chk("R10 next dir", dir_rd_o, 1'b1);

        // R9: wake behaviour
        sleep_i = 1'b0;
        send_start();
        send_byte(8'h54);
        chk("R9 awake no wake", wake_o, 1'b0);
        sleep_i = 1'b1;
        send_start();
        send_byte(8'h13);                 // miss
        chk("R9 miss no wake", wake_o, 1'b0);
        send_start();
        send_byte(8'h54);
        chk("R9 wake with match", wake_o, 1'b1);
        chk("R9 match same cycle", match_o, 1'b1);
        repeat (3) @(negedge clk);
        chk("R9 wake held", wake_o, 1'b1);
        sleep_i = 1'b0;
        @(negedge clk);
        chk("R9 wake cleared", wake_o, 1'b0);
        ack_en_i = 1'b0; sleep_i = 1'b1;
        send_start();
        send_byte(8'h00);                 // general call, ACK disabled
        chk("R9 gc wakes", wake_o, 1'b1);
        chk("R6 gc nack", ack_drive_o, 1'b1);
        sleep_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule